// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises bytes onto a single transmit line in asynchronous start/stop framing. Bytes arrive on a write strobe and wait in a small holding queue. A frame engine pulls one byte at a time and shifts it out. Every bit is held for a fixed number of baud-tick strobes, so the line rate follows whatever tick source the surrounding chip supplies.

The frame shape is chosen at run time from a line-control byte. That byte sets the data length (5 to 8 bits), turns an optional parity bit on or off, picks even or odd parity, and selects one or two stop bits. The same byte decides whether the queue holds up to sixteen bytes or acts as a single holding register. A control word holds two enables, and both must be set before a frame starts. The format is captured when a frame starts. Dropping an enable part-way through a frame lets that frame finish, and no further frame begins.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `txd` is high, `busy` is low, `fifo_empty` is high and `fifo_full` is low.
- R2: A frame is one low start bit, then the data bits least significant first, then high stop bits. The data length is `line_ctrl[6:5]` plus five (00 gives 5 bits, 11 gives 8 bits).
- R3: When `line_ctrl[1]` is set, a parity bit follows the data. It covers only the active data bits. When `line_ctrl[2]` is 1, the number of ones across the data and parity bits is even; when it is 0, that number is odd.
- R4: `line_ctrl[3]` set sends two stop bits; clear sends one.
- R5: Each frame bit lasts exactly 16 `baud_tick` strobes, and `txd` only changes on a clock edge where `baud_tick` is high or where a frame starts.
- R6: A frame starts only while both `ctrl_word[0]` (global enable) and `ctrl_word[8]` (transmit enable) are 1. With either one at 0, queued bytes stay queued and `txd` stays high.
- R7: Clearing an enable during a frame lets that frame finish intact. The next queued byte is not sent until both enables are set again.
- R8: With `line_ctrl[4]` set, the queue holds 16 bytes and sends them in write order. `fifo_full` rises on the 16th byte, and a write while full is discarded.
- R9: With `line_ctrl[4]` clear, the queue holds a single byte. `fifo_full` is high while that byte waits, and a second write is discarded.
- R10: `busy` is high from the cycle a start bit begins until the last stop bit has lasted its full time. Back-to-back frames are separated by at most one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to queue |
| ctrl_word | input | 9 | Bit 0 global enable, bit 8 transmit enable; other bits ignored |
| line_ctrl | input | 8 | Frame format and queue mode; bit 0 ignored |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is on the line |
| fifo_full | output | 1 | Queue cannot accept a write |
| fifo_empty | output | 1 | Queue holds no byte |

## Verification
The assertions assume that `line_ctrl` is held stable from the moment a byte is written until its frame starts. They also assume that `wr_en` is a single-cycle strobe that the bench never raises on a cycle where the engine pops. The stimulus changes format and enables only while the line is idle and the queue is empty, except in the two tests that deliberately drop an enable in mid-frame or load the queue before enabling. Nearly every test holds the tick high on every cycle so that mid-bit sampling points fall at fixed clock counts. One frame uses a tick every third cycle to show that the bit time scales with the strobe.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

   // Line-control bit positions (decoded by the frame engine and queue)
   localparam int LC_PAR_EN   = 1;
   localparam int LC_PAR_EVEN = 2;
   localparam int LC_TWO_STOP = 3;
   localparam int LC_FIFO_EN  = 4;
   localparam int LC_LEN_LO   = 5;

   // Control-word enables
   localparam int CT_GLOBAL_EN = 0;
   localparam int CT_TX_EN     = 8;

   // Longest frame: start + 8 data + parity + 2 stop
   localparam int FRAME_MAX = 12;
   localparam int FLEN_W    = $clog2(FRAME_MAX + 1);

   typedef struct packed {
      logic [1:0] len_code;
      logic       par_en;
      logic       par_even;
      logic       two_stop;
   } fmt_t;

   function automatic fmt_t decode_line(input logic [7:0] lc);
      fmt_t f;
      f.len_code = lc[LC_LEN_LO +: 2];
      f.par_en   = lc[LC_PAR_EN];
      f.par_even = lc[LC_PAR_EVEN];
      f.two_stop = lc[LC_TWO_STOP];
      return f;
   endfunction

   // Frame image, bit 0 goes out first; unused upper bits stay 1 (stop level)
   function automatic logic [FRAME_MAX-1:0] pack_frame(input fmt_t f, input logic [7:0] d);
      logic [FRAME_MAX-1:0] v;
      logic [7:0]           m;
      logic                 p;
      int                   nb;
      m  = 8'hFF >> (2'd3 - f.len_code);
      nb = 5 + int'(f.len_code);
      p  = (^(d & m)) ^ ~f.par_even;
      v  = '1;
      v[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i < nb) v[1 + i] = d[i];
      end
      if (f.par_en) v[1 + nb] = p;
      return v;
   endfunction

   function automatic logic [FLEN_W-1:0] frame_len(input fmt_t f);
      return FLEN_W'(7) + FLEN_W'(f.len_code) + FLEN_W'(f.par_en) + FLEN_W'(f.two_stop);
   endfunction

endpackage

// File: rtl/uart_txf_fifo.sv
module uart_txf_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         buf_en,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] hold_q;
         logic         valid_q;
         logic         single_unused;
         assign single_unused = buf_en;
         assign full  = valid_q;
         assign empty = !valid_q;
         assign dout  = hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               hold_q  <= '0;
            end else if (push && !valid_q) begin
               valid_q <= 1'b1;
               hold_q  <= din;
            end else if (pop && valid_q) begin
               valid_q <= 1'b0;
            end
         end
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wp_q, rp_q;
         logic [CNT_W-1:0] cnt_q;
         logic             do_push, do_pop;

         assign full    = buf_en ? (cnt_q == CNT_W'(DEPTH)) : (cnt_q != '0);
         assign empty   = (cnt_q == '0);
         assign do_push = push && !full;
         assign do_pop  = pop && !empty;
         assign dout    = mem[rp_q];

         always_ff @(posedge clk) begin
            if (do_push) mem[wp_q] <= din;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push) wp_q <= wp_q + 1'b1;
               if (do_pop)  rp_q <= rp_q + 1'b1;
               cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
            end
         end

         // R8
         drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            push && full && !pop |=> $stable(cnt_q));
         // R8
         count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(DEPTH));
      end
   endgenerate

endmodule

// File: rtl/uart_txf_shifter.sv
module uart_txf_shifter
   import uart_txf_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       go_ok,
   input  logic       have_data,
   input  logic [7:0] data,
   input  fmt_t       fmt,
   output logic       pop,
   output logic       txd,
   output logic       busy
);

   localparam int TICK_W = $clog2(OVERSAMPLE);
   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);

   logic [FRAME_MAX-1:0] shreg_q;
   logic [FLEN_W-1:0]    left_q;
   logic [TICK_W-1:0]    tick_q;
   logic                 txd_q, busy_q;
   logic [FRAME_MAX-1:0] image;

   assign image = pack_frame(fmt, data);
   assign pop   = !busy_q && have_data && go_ok;
   assign txd   = txd_q;
   assign busy  = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '1;
         left_q  <= '0;
         tick_q  <= '0;
         txd_q   <= 1'b1;
         busy_q  <= 1'b0;
      end else if (pop) begin
         shreg_q <= {1'b1, image[FRAME_MAX-1:1]};
         txd_q   <= image[0];
         left_q  <= frame_len(fmt);
         tick_q  <= '0;
         busy_q  <= 1'b1;
      end else if (busy_q && baud_tick) begin
         if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            if (left_q == FLEN_W'(1)) begin
               busy_q <= 1'b0;
               txd_q  <= 1'b1;
            end else begin
               txd_q   <= shreg_q[0];
               shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
               left_q  <= left_q - 1'b1;
            end
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end

   // R1
   line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !txd_q |-> busy_q);
   // R5
   tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !baud_tick |=> busy_q && $stable(txd_q));
   // R6
   start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(go_ok));
   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !txd_q);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uart_txf_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic [8:0] ctrl_word,
   input  logic [7:0] line_ctrl,
   output logic       txd,
   output logic       busy,
   output logic       fifo_full,
   output logic       fifo_empty
);

   generate
      if (FIFO_DEPTH < 1 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two");
      end
      if (OVERSAMPLE < 2 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be a power of two of at least 2");
      end
   endgenerate

   fmt_t       fmt;
   logic       go_ok, pop;
   logic [7:0] head;
   logic       ctl_unused;

   assign fmt        = decode_line(line_ctrl);
   assign go_ok      = ctrl_word[CT_GLOBAL_EN] && ctrl_word[CT_TX_EN];
   assign ctl_unused = ^{ctrl_word[7:1], line_ctrl[0]};

   uart_txf_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .buf_en(line_ctrl[LC_FIFO_EN]),
      .push  (wr_en),
      .din   (wr_data),
      .pop   (pop),
      .dout  (head),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   uart_txf_shifter #(.OVERSAMPLE(OVERSAMPLE)) i_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .baud_tick(baud_tick),
      .go_ok    (go_ok),
      .have_data(!fifo_empty),
      .data     (head),
      .fmt      (fmt),
      .pop      (pop),
      .txd      (txd),
      .busy     (busy)
   );

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> !fifo_empty);

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [8:0] ctrl_word = '0;
   logic [7:0] line_ctrl = '0;
   logic       txd, busy, fifo_full, fifo_empty;

   int vectors = 0;
   int miscompares = 0;
   int tick_div = 1;
   int tick_ph = 0;

   uart_frame_tx i_uart_frame_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_data(wr_data), .ctrl_word(ctrl_word), .line_ctrl(line_ctrl),
      .txd(txd), .busy(busy), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (tick_ph + 1 >= tick_div) begin
         tick_ph = 0;
         baud_tick = 1'b1;
      end else begin
         tick_ph = tick_ph + 1;
         baud_tick = 1'b0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Waits for a start bit and checks the whole frame at mid-bit points
   task automatic recv(input logic [7:0] d, input logic [7:0] lc, input bit idle_after, input string req);
      logic [11:0] e;
      int nb, len;
      logic p;
      bit found;
      found = 0;
      for (int k = 0; k < 3000 && !found; k++) begin
         @(negedge clk);
         if (txd === 1'b0) found = 1;
      end
      if (!found) begin
         chk({req, " start bit"}, 0, 1);
         return;
      end
      nb = 5 + int'(lc[6:5]);
      e = '1;
      e[0] = 1'b0;
      p = 1'b0;
      for (int i = 0; i < nb; i++) begin
         e[1 + i] = d[i];
         p = p ^ d[i];
      end
      len = 1 + nb;
      if (lc[1]) begin
         e[len] = lc[2] ? p : ~p;
         len++;
      end
      len += lc[3] ? 2 : 1;
      repeat (8) @(negedge clk);
      for (int i = 0; i < len; i++) begin
         chk($sformatf("%s frame bit %0d of %02h lc=%02h", req, i, d, lc), txd, e[i]);
         if (i < len - 1) repeat (16) @(negedge clk);
      end
      repeat (8) @(negedge clk);
      if (idle_after) begin
         chk({req, " R10 busy after frame"}, busy, 0);
         chk({req, " R10 line high after frame"}, txd, 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog R10 actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 txd", txd, 1);
      chk("R1 busy", busy, 0);
      chk("R1 empty", fifo_empty, 1);
      chk("R1 full", fifo_full, 0);

      // R2 R3 R4: sweep every length, parity mode and stop count
      ctrl_word = 9'h101;
      for (int len = 0; len < 4; len++) begin
         for (int pm = 0; pm < 3; pm++) begin
            for (int st = 0; st < 2; st++) begin
               logic [7:0] lc;
               logic [7:0] b;
               lc = {1'b0, 2'(len), 1'b1, 1'(st), (pm == 2) ? 1'b1 : 1'b0, (pm != 0) ? 1'b1 : 1'b0, 1'b0};
               line_ctrl = lc;
               for (int j = 0; j < 3; j++) begin
                  b = (j == 0) ? 8'hA5 : (j == 1) ? 8'(8'h5A ^ (len * 37 + pm * 11 + st)) : 8'h00;
                  put(b);
                  recv(b, lc, 1, "R2 R3 R4");
               end
            end
         end
      end

      // R6: each enable alone holds the byte back
      line_ctrl = 8'h70;
      ctrl_word = 9'h001;
      put(8'hC3);
      repeat (100) @(negedge clk);
      chk("R6 global only busy", busy, 0);
      chk("R6 global only txd", txd, 1);
      chk("R6 global only queued", fifo_empty, 0);
      ctrl_word = 9'h100;
      repeat (100) @(negedge clk);
      chk("R6 tx only busy", busy, 0);
      chk("R6 tx only txd", txd, 1);
      ctrl_word = 9'h101;
      recv(8'hC3, 8'h70, 1, "R6 both enables");

      // R5: slower tick stretches the bit time
      tick_div = 3;
      put(8'h01);
      begin
         int lowc;
         bit seen;
         seen = 0;
         lowc = 0;
         for (int k = 0; k < 200 && !seen; k++) begin
            @(negedge clk);
            if (txd === 1'b0) seen = 1;
         end
         lowc = 1;
         for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (txd !== 1'b0) break;
            lowc++;
         end
         chk($sformatf("R5 start bit length %0d", lowc), (lowc >= 46 && lowc <= 48) ? 1 : 0, 1);
         for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
         chk("R5 slow frame ends", busy, 0);
      end
      tick_div = 1;
      repeat (4) @(negedge clk);

      // R7: drop enable mid-frame
      ctrl_word = 9'h000;
      put(8'h96);
      put(8'h69);
      ctrl_word = 9'h101;
      fork
         recv(8'h96, 8'h70, 1, "R7 frame finishes");
         begin
            repeat (60) @(negedge clk);
            ctrl_word = 9'h100;
         end
      join
      repeat (200) @(negedge clk);
      chk("R7 next held busy", busy, 0);
      chk("R7 next held txd", txd, 1);
      chk("R7 next held queued", fifo_empty, 0);
      ctrl_word = 9'h101;
      recv(8'h69, 8'h70, 1, "R7 resumed");

      // R8: sixteen-entry queue, overflow discarded
      ctrl_word = 9'h000;
      line_ctrl = 8'h70;
      for (int i = 0; i < 16; i++) begin
         put(8'(i * 17 + 3));
         if (i == 14) chk("R8 not full at 15", fifo_full, 0);
      end
      chk("R8 full at 16", fifo_full, 1);
      put(8'hEE);
      chk("R8 still full", fifo_full, 1);
      ctrl_word = 9'h101;
      for (int i = 0; i < 16; i++) begin
         recv(8'(i * 17 + 3), 8'h70, (i == 15), "R8 order");
      end
      repeat (300) @(negedge clk);
      chk("R8 overflow dropped txd", txd, 1);
      chk("R8 overflow dropped busy", busy, 0);
      chk("R8 drained", fifo_empty, 1);

      // R9: single-entry holding register
      ctrl_word = 9'h000;
      line_ctrl = 8'h60;
      put(8'h81);
      chk("R9 full with one", fifo_full, 1);
      chk("R9 not empty", fifo_empty, 0);
      put(8'h7E);
      ctrl_word = 9'h101;
      recv(8'h81, 8'h60, 1, "R9 held byte");
      repeat (300) @(negedge clk);
      chk("R9 second dropped busy", busy, 0);
      chk("R9 second dropped empty", fifo_empty, 1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule